// File: doc/BRIEF.md
# DMA Channel Error Handler

This block sits beside a multi-channel, descriptor-driven DMA engine that has a set of transmit channels and a set of receive channels. Each cycle it may see one descriptor-check result from the fetch logic, one error event from the peripheral bus, and one slave error from the system bus. From these it works out which errors count, which channel (if any) must stop, and what to record.

Each channel has an Active bit. An error tied to a channel clears that bit and marks the channel halted. Software restarts the channel by writing its set strobe. Restarting a halted channel sends a one-cycle pulse that returns the channel's descriptor pointer to the head of its table. Descriptor errors also set a per-channel bit in a transmit or receive descriptor-error vector. Either vector being non-zero drives a nonmaskable interrupt.

A single status record holds the error type, the channel, and a flag that says whether the channel is known. The record either follows the most recent error or, in locked mode, keeps the first error until software clears it.

Top module: `dma_err_ctl`

## Requirements
- R1: A descriptor check with its ready flag low is a descriptor error on any receive channel.
- R2: On a transmit channel, a not-ready descriptor is not an error if it is the first descriptor of a packet, or if it belongs to a backed-up packet and is not the last descriptor of that packet. Such a check leaves every output unchanged.
- R3: An error tied to a channel clears that channel's Active bit on the next clock edge. The channel stays inactive until its software set strobe is written. If the set strobe and the error arrive in the same cycle, the error wins.
- R4: A descriptor error sets the channel's bit in `tx_deir` or `rx_deir`. The bit is cleared by writing 1 to the matching clear strobe. A new set in the same cycle takes priority over the clear.
- R5: `txde_irq` is high exactly when some bit of `tx_deir` is set, and `rxde_irq` is high exactly when some bit of `rx_deir` is set. Neither interrupt can be masked.
- R6: If the set strobe of a halted channel is written in a cycle with no error on that channel, the channel's pointer-reset output pulses high for exactly one cycle, one cycle after the write. Writing the set strobe of a channel that was not halted gives no pulse.
- R7: A peripheral-bus error halts the channel it names. Its kind field selects the type: 00 is a non-fullword acknowledge, 01 is an arbiter time-out, and 1x is a general bus error.
- R8: A system-bus error halts no channel. It is recorded with type 5 and `esr_chv` low, and with `esr_rx` and `esr_chan` both zero.
- R9: The status type codes are 1 for descriptor, 2 for non-fullword, 3 for time-out, 4 for peripheral bus and 5 for system bus. The status record updates one cycle after the error.
- R10: When several errors arrive in one cycle, the status record takes the one with the smallest rank {rx, chan}, where transmit channels rank below receive channels. A descriptor error wins a tie. The system-bus error ranks last. Every halt and every descriptor-error bit is still applied.
- R11: While `lock_mode` is high, the first recorded error sets `esr_locked`. A locked record is held against all later errors.
- R12: Writing 1 to `esr_clr` clears the record and the lock. If an error arrives in the same cycle, that error is recorded instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dchk_vld | input | 1 | Descriptor check result valid |
| dchk_rx | input | 1 | Check is for a receive channel |
| dchk_chan | input | CW | Channel number of the check |
| dchk_ready | input | 1 | Ready flag of the fetched descriptor |
| dchk_first | input | 1 | Descriptor is the first of its packet |
| dchk_last | input | 1 | Descriptor is the last of its packet |
| dchk_backed | input | 1 | Descriptor belongs to a backed-up packet |
| pb_err_vld | input | 1 | Peripheral-bus error event |
| pb_err_kind | input | 2 | 00 non-fullword, 01 time-out, 1x general |
| pb_err_rx | input | 1 | Peripheral error is on a receive channel |
| pb_err_chan | input | CW | Channel of the peripheral error |
| sb_err | input | 1 | System-bus slave error |
| act_set_tx | input | NCH | Write-1-to-set Active, transmit |
| act_set_rx | input | NCH | Write-1-to-set Active, receive |
| deir_clr_tx | input | NCH | Write-1-to-clear descriptor error, transmit |
| deir_clr_rx | input | NCH | Write-1-to-clear descriptor error, receive |
| lock_mode | input | 1 | Keep the first error in the status record |
| esr_clr | input | 1 | Write-1-to-clear status record and lock |
| tx_active | output | NCH | Active bits, transmit |
| rx_active | output | NCH | Active bits, receive |
| tx_ptr_rst | output | NCH | Pointer-to-head pulse, transmit |
| rx_ptr_rst | output | NCH | Pointer-to-head pulse, receive |
| tx_deir | output | NCH | Descriptor error bits, transmit |
| rx_deir | output | NCH | Descriptor error bits, receive |
| txde_irq | output | 1 | Transmit descriptor error interrupt |
| rxde_irq | output | 1 | Receive descriptor error interrupt |
| esr_vld | output | 1 | Status record holds an error |
| esr_locked | output | 1 | Status record is locked |
| esr_type | output | 3 | Error type code |
| esr_chv | output | 1 | Channel field is meaningful |
| esr_rx | output | 1 | Recorded channel is a receive channel |
| esr_chan | output | CW | Recorded channel number |

## Verification
The bench targets the transmit exceptions for first and backed-up non-last descriptors. A design that got these wrong would halt a healthy channel and raise a false interrupt. It also targets a set strobe that meets an error in the same cycle, where a wrong design would leave the channel running or send a spurious pointer reset. Two more cases are a set-plus-clear collision on a descriptor-error bit, where the error would be lost, and errors from both buses arriving together. In that last case a wrong priority would record the wrong channel, or the system-bus error would halt a channel. Locked mode is exercised against streams of later errors and against a clear that coincides with a new error.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

    typedef enum logic [2:0] {
        ET_NONE  = 3'd0,
        ET_DESC  = 3'd1,
        ET_NONFW = 3'd2,
        ET_TMO   = 3'd3,
        ET_PBUS  = 3'd4,
        ET_SBUS  = 3'd5
    } err_type_e;

    typedef struct packed {
        err_type_e etype;
        logic      chv;
        logic      rx;
    } err_tag_t;

    // A not-ready descriptor is a fault unless a transmit exception covers it.
    function automatic logic desc_fault(input logic rx, input logic ready,
                                        input logic first, input logic last,
                                        input logic backed);
        logic excused;
        excused = !rx && (first || (backed && !last));
        return !ready && !excused;
    endfunction

    function automatic err_type_e pb_type(input logic [1:0] kind);
        case (kind)
            2'b00:   return ET_NONFW;
            2'b01:   return ET_TMO;
            default: return ET_PBUS;
        endcase
    endfunction

endpackage

// File: rtl/dma_err_classify.sv
module dma_err_classify
    import dma_err_pkg::*;
#(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic            dchk_vld,
    input  logic            dchk_rx,
    input  logic [CW-1:0]   dchk_chan,
    input  logic            dchk_ready,
    input  logic            dchk_first,
    input  logic            dchk_last,
    input  logic            dchk_backed,
    input  logic            pb_err_vld,
    input  logic [1:0]      pb_err_kind,
    input  logic            pb_err_rx,
    input  logic [CW-1:0]   pb_err_chan,
    input  logic            sb_err,
    output logic [NCH-1:0]  tx_halt,
    output logic [NCH-1:0]  rx_halt,
    output logic [NCH-1:0]  tx_dset,
    output logic [NCH-1:0]  rx_dset,
    output logic            rec_vld,
    output err_tag_t        rec_tag,
    output logic [CW-1:0]   rec_chan
);

    logic            d_fault;
    logic [CW:0]     d_rank;
    logic [CW:0]     p_rank;
    logic [NCH-1:0]  tx_pb;
    logic [NCH-1:0]  rx_pb;

    always_comb begin
        d_fault = dchk_vld && desc_fault(dchk_rx, dchk_ready, dchk_first,
                                         dchk_last, dchk_backed);
        d_rank  = {dchk_rx, dchk_chan};
        p_rank  = {pb_err_rx, pb_err_chan};

        tx_dset = '0;
        rx_dset = '0;
        tx_pb   = '0;
        rx_pb   = '0;
        if (d_fault) begin
            if (dchk_rx) rx_dset[dchk_chan] = 1'b1;
            else         tx_dset[dchk_chan] = 1'b1;
        end
        if (pb_err_vld) begin
            if (pb_err_rx) rx_pb[pb_err_chan] = 1'b1;
            else           tx_pb[pb_err_chan] = 1'b1;
        end
        tx_halt = tx_dset | tx_pb;
        rx_halt = rx_dset | rx_pb;

        rec_vld  = 1'b1;
        rec_tag  = '{etype: ET_NONE, chv: 1'b0, rx: 1'b0};
        rec_chan = '0;
        if (d_fault && (!pb_err_vld || d_rank <= p_rank)) begin
            rec_tag  = '{etype: ET_DESC, chv: 1'b1, rx: dchk_rx};
            rec_chan = dchk_chan;
        end else if (pb_err_vld) begin
            rec_tag  = '{etype: pb_type(pb_err_kind), chv: 1'b1, rx: pb_err_rx};
            rec_chan = pb_err_chan;
        end else if (sb_err) begin
            rec_tag  = '{etype: ET_SBUS, chv: 1'b0, rx: 1'b0};
        end else begin
            rec_vld  = 1'b0;
        end
    end

endmodule

// File: rtl/dma_err_chan.sv
module dma_err_chan #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] halt,
    input  logic [NCH-1:0] dset,
    input  logic [NCH-1:0] act_set,
    input  logic [NCH-1:0] deir_clr,
    output logic [NCH-1:0] active,
    output logic [NCH-1:0] ptr_rst,
    output logic [NCH-1:0] deir
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic act_q, halted_q, ptr_q, deir_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                act_q    <= 1'b0;
                halted_q <= 1'b0;
                ptr_q    <= 1'b0;
                deir_q   <= 1'b0;
            end else begin
                ptr_q <= act_set[i] && halted_q && !halt[i];
                if (halt[i]) begin
                    act_q    <= 1'b0;
                    halted_q <= 1'b1;
                end else if (act_set[i]) begin
                    act_q    <= 1'b1;
                    halted_q <= 1'b0;
                end
                if (dset[i])          deir_q <= 1'b1;
                else if (deir_clr[i]) deir_q <= 1'b0;
            end
        end

        assign active[i]  = act_q;
        assign ptr_rst[i] = ptr_q;
        assign deir[i]    = deir_q;
    end

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
    import dma_err_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rec_vld,
    input  err_tag_t      rec_tag,
    input  logic [CW-1:0] rec_chan,
    input  logic          lock_mode,
    input  logic          esr_clr,
    output logic          esr_vld,
    output logic          esr_locked,
    output logic [2:0]    esr_type,
    output logic          esr_chv,
    output logic          esr_rx,
    output logic [CW-1:0] esr_chan
);

    err_tag_t      tag_q;
    logic [CW-1:0] chan_q;
    logic          vld_q, lock_q;
    logic          hold;

    assign hold = lock_mode && lock_q && !esr_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            lock_q <= 1'b0;
            tag_q  <= '{etype: ET_NONE, chv: 1'b0, rx: 1'b0};
            chan_q <= '0;
        end else if (rec_vld && !hold) begin
            vld_q  <= 1'b1;
            lock_q <= lock_mode;
            tag_q  <= rec_tag;
            chan_q <= rec_chan;
        end else if (esr_clr) begin
            vld_q  <= 1'b0;
            lock_q <= 1'b0;
            tag_q  <= '{etype: ET_NONE, chv: 1'b0, rx: 1'b0};
            chan_q <= '0;
        end
    end

    assign esr_vld    = vld_q;
    assign esr_locked = lock_q;
    assign esr_type   = tag_q.etype;
    assign esr_chv    = tag_q.chv;
    assign esr_rx     = tag_q.rx;
    assign esr_chan   = chan_q;

endmodule

// File: rtl/dma_err_ctl.sv
module dma_err_ctl
    import dma_err_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           dchk_vld,
    input  logic           dchk_rx,
    input  logic [CW-1:0]  dchk_chan,
    input  logic           dchk_ready,
    input  logic           dchk_first,
    input  logic           dchk_last,
    input  logic           dchk_backed,
    input  logic           pb_err_vld,
    input  logic [1:0]     pb_err_kind,
    input  logic           pb_err_rx,
    input  logic [CW-1:0]  pb_err_chan,
    input  logic           sb_err,
    input  logic [NCH-1:0] act_set_tx,
    input  logic [NCH-1:0] act_set_rx,
    input  logic [NCH-1:0] deir_clr_tx,
    input  logic [NCH-1:0] deir_clr_rx,
    input  logic           lock_mode,
    input  logic           esr_clr,
    output logic [NCH-1:0] tx_active,
    output logic [NCH-1:0] rx_active,
    output logic [NCH-1:0] tx_ptr_rst,
    output logic [NCH-1:0] rx_ptr_rst,
    output logic [NCH-1:0] tx_deir,
    output logic [NCH-1:0] rx_deir,
    output logic           txde_irq,
    output logic           rxde_irq,
    output logic           esr_vld,
    output logic           esr_locked,
    output logic [2:0]     esr_type,
    output logic           esr_chv,
    output logic           esr_rx,
    output logic [CW-1:0]  esr_chan
);

    logic [NCH-1:0] tx_halt, rx_halt, tx_dset, rx_dset;
    logic           rec_vld;
    err_tag_t       rec_tag;
    logic [CW-1:0]  rec_chan;

    dma_err_classify #(.NCH(NCH), .CW(CW)) u_cls (
        .dchk_vld(dchk_vld), .dchk_rx(dchk_rx), .dchk_chan(dchk_chan),
        .dchk_ready(dchk_ready), .dchk_first(dchk_first),
        .dchk_last(dchk_last), .dchk_backed(dchk_backed),
        .pb_err_vld(pb_err_vld), .pb_err_kind(pb_err_kind),
        .pb_err_rx(pb_err_rx), .pb_err_chan(pb_err_chan), .sb_err(sb_err),
        .tx_halt(tx_halt), .rx_halt(rx_halt),
        .tx_dset(tx_dset), .rx_dset(rx_dset),
        .rec_vld(rec_vld), .rec_tag(rec_tag), .rec_chan(rec_chan)
    );

    dma_err_chan #(.NCH(NCH)) u_tx (
        .clk(clk), .rst(rst), .halt(tx_halt), .dset(tx_dset),
        .act_set(act_set_tx), .deir_clr(deir_clr_tx),
        .active(tx_active), .ptr_rst(tx_ptr_rst), .deir(tx_deir)
    );

    dma_err_chan #(.NCH(NCH)) u_rx (
        .clk(clk), .rst(rst), .halt(rx_halt), .dset(rx_dset),
        .act_set(act_set_rx), .deir_clr(deir_clr_rx),
        .active(rx_active), .ptr_rst(rx_ptr_rst), .deir(rx_deir)
    );

    dma_err_status #(.CW(CW)) u_esr (
        .clk(clk), .rst(rst), .rec_vld(rec_vld), .rec_tag(rec_tag),
        .rec_chan(rec_chan), .lock_mode(lock_mode), .esr_clr(esr_clr),
        .esr_vld(esr_vld), .esr_locked(esr_locked), .esr_type(esr_type),
        .esr_chv(esr_chv), .esr_rx(esr_rx), .esr_chan(esr_chan)
    );

    assign txde_irq = |tx_deir;
    assign rxde_irq = |rx_deir;

endmodule

// File: rtl/dma_err_ctl_chk.sv
module dma_err_ctl_chk #(
    parameter int NCH = 4,
    localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst,
    input logic           dchk_vld,
    input logic           dchk_rx,
    input logic           dchk_first,
    input logic           pb_err_vld,
    input logic           pb_err_rx,
    input logic [CW-1:0]  pb_err_chan,
    input logic           sb_err,
    input logic [NCH-1:0] act_set_tx,
    input logic [NCH-1:0] act_set_rx,
    input logic [NCH-1:0] deir_clr_tx,
    input logic           lock_mode,
    input logic           esr_clr,
    input logic [NCH-1:0] tx_active,
    input logic [NCH-1:0] rx_active,
    input logic [NCH-1:0] tx_ptr_rst,
    input logic [NCH-1:0] rx_ptr_rst,
    input logic [NCH-1:0] tx_deir,
    input logic           txde_irq,
    input logic           rxde_irq,
    input logic           esr_locked,
    input logic [2:0]     esr_type,
    input logic           esr_chv,
    input logic           esr_rx,
    input logic [CW-1:0]  esr_chan
);

    // R2
    tx_first_excused_chk: assert property (@(posedge clk) disable iff (rst)
        dchk_vld && !dchk_rx && dchk_first && !pb_err_vld
        |=> tx_deir == ($past(tx_deir) & ~$past(deir_clr_tx)));

    // R3
    tx_pb_halt_chk: assert property (@(posedge clk) disable iff (rst)
        pb_err_vld && !pb_err_rx |=> !tx_active[$past(pb_err_chan)]);

    // R3
    rx_pb_halt_chk: assert property (@(posedge clk) disable iff (rst)
        pb_err_vld && pb_err_rx |=> !rx_active[$past(pb_err_chan)]);

    // R5
    txde_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(txde_irq) |-> $past(dchk_vld && !dchk_rx));

    // R5
    rxde_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rxde_irq) |-> $past(dchk_vld && dchk_rx));

    // R6
    ptr_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|tx_ptr_rst) || (|rx_ptr_rst) |-> $past((|act_set_tx) || (|act_set_rx)));

    // R8
    sbus_no_halt_chk: assert property (@(posedge clk) disable iff (rst)
        sb_err && !dchk_vld && !pb_err_vld && act_set_tx == '0 && act_set_rx == '0
        |=> tx_active == $past(tx_active) && rx_active == $past(rx_active));

    // R8
    sbus_record_chk: assert property (@(posedge clk) disable iff (rst)
        sb_err && !dchk_vld && !pb_err_vld && !(lock_mode && esr_locked && !esr_clr)
        |=> esr_type == 3'd5 && !esr_chv);

    // R11
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lock_mode && esr_locked && !esr_clr
        |=> $stable(esr_type) && $stable(esr_chan) && $stable(esr_rx) && esr_locked);

endmodule

bind dma_err_ctl dma_err_ctl_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/dma_err_ctl_tb_top.sv
module dma_err_ctl_tb_top;
    localparam int NCH = 4;
    localparam int CW  = 2;

    logic clk = 1'b0;
    logic rst;
    logic dchk_vld, dchk_rx, dchk_ready, dchk_first, dchk_last, dchk_backed;
    logic [CW-1:0] dchk_chan, pb_err_chan;
    logic pb_err_vld, pb_err_rx, sb_err, lock_mode, esr_clr;
    logic [1:0] pb_err_kind;
    logic [NCH-1:0] act_set_tx, act_set_rx, deir_clr_tx, deir_clr_rx;
    logic [NCH-1:0] tx_active, rx_active, tx_ptr_rst, rx_ptr_rst, tx_deir, rx_deir;
    logic txde_irq, rxde_irq, esr_vld, esr_locked, esr_chv, esr_rx;
    logic [2:0] esr_type;
    logic [CW-1:0] esr_chan;

    always #10 clk = ~clk;

    dma_err_ctl #(.NCH(NCH)) dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model state
    logic [NCH-1:0] m_tact, m_ract, m_thlt, m_rhlt, m_tptr, m_rptr, m_tdeir, m_rdeir;
    logic m_vld, m_lck, m_chv, m_rx;
    logic [2:0] m_type;
    logic [CW-1:0] m_chan;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_fault(input logic rx, ready, first, last, backed);
        if (ready) return 1'b0;
        if (rx) return 1'b1;
        return !(first || (backed && !last));
    endfunction

    function automatic logic [2:0] m_pbtype(input logic [1:0] k);
        return (k == 2'b00) ? 3'd2 : (k == 2'b01) ? 3'd3 : 3'd4;
    endfunction

    task automatic model_reset();
        {m_tact, m_ract, m_thlt, m_rhlt, m_tptr, m_rptr, m_tdeir, m_rdeir} = '0;
        {m_vld, m_lck, m_chv, m_rx, m_type, m_chan} = '0;
    endtask

    task automatic model_step();
        logic [NCH-1:0] th, rh, td, rd;
        bit df, rv, hold;
        logic [2:0] rt; logic rc, rr; logic [CW-1:0] rch;
        th = '0; rh = '0; td = '0; rd = '0;
        df = dchk_vld && m_fault(dchk_rx, dchk_ready, dchk_first, dchk_last, dchk_backed);
        if (df) begin if (dchk_rx) rd[dchk_chan] = 1'b1; else td[dchk_chan] = 1'b1; end
        th = td; rh = rd;
        if (pb_err_vld) begin if (pb_err_rx) rh[pb_err_chan] = 1'b1; else th[pb_err_chan] = 1'b1; end
        for (int i = 0; i < NCH; i++) begin
            m_tptr[i] = act_set_tx[i] && m_thlt[i] && !th[i];
            m_rptr[i] = act_set_rx[i] && m_rhlt[i] && !rh[i];
            if (th[i]) begin m_tact[i] = 0; m_thlt[i] = 1; end
            else if (act_set_tx[i]) begin m_tact[i] = 1; m_thlt[i] = 0; end
            if (rh[i]) begin m_ract[i] = 0; m_rhlt[i] = 1; end
            else if (act_set_rx[i]) begin m_ract[i] = 1; m_rhlt[i] = 0; end
            if (td[i]) m_tdeir[i] = 1; else if (deir_clr_tx[i]) m_tdeir[i] = 0;
            if (rd[i]) m_rdeir[i] = 1; else if (deir_clr_rx[i]) m_rdeir[i] = 0;
        end
        rv = 1; rt = 0; rc = 0; rr = 0; rch = 0;
        if (df && (!pb_err_vld || {dchk_rx, dchk_chan} <= {pb_err_rx, pb_err_chan})) begin
            rt = 1; rc = 1; rr = dchk_rx; rch = dchk_chan;
        end else if (pb_err_vld) begin
            rt = m_pbtype(pb_err_kind); rc = 1; rr = pb_err_rx; rch = pb_err_chan;
        end else if (sb_err) rt = 5;
        else rv = 0;
        hold = lock_mode && m_lck && !esr_clr;
        if (rv && !hold) begin
            m_vld = 1; m_lck = lock_mode; m_type = rt; m_chv = rc; m_rx = rr; m_chan = rch;
        end else if (esr_clr) begin
            {m_vld, m_lck, m_chv, m_rx, m_type, m_chan} = '0;
        end
    endtask

    task automatic compare();
        chk(tx_active == m_tact, "R3 tx_active", tx_active, m_tact);
        chk(rx_active == m_ract, "R3 rx_active", rx_active, m_ract);
        chk(tx_deir == m_tdeir, "R1/R2/R4 tx_deir", tx_deir, m_tdeir);
        chk(rx_deir == m_rdeir, "R1 R4 rx_deir", rx_deir, m_rdeir);
        chk(txde_irq == |m_tdeir, "R5 txde_irq", txde_irq, |m_tdeir);
        chk(rxde_irq == |m_rdeir, "R5 rxde_irq", rxde_irq, |m_rdeir);
        chk(tx_ptr_rst == m_tptr, "R6 tx_ptr_rst", tx_ptr_rst, m_tptr);
        chk(rx_ptr_rst == m_rptr, "R6 rx_ptr_rst", rx_ptr_rst, m_rptr);
        chk(esr_type == m_type, "R7 R9 R10 esr_type", esr_type, m_type);
        chk({esr_chv, esr_rx, esr_chan} == {m_chv, m_rx, m_chan}, "R8 R10 esr_chan",
            {esr_chv, esr_rx, esr_chan}, {m_chv, m_rx, m_chan});
        chk({esr_vld, esr_locked} == {m_vld, m_lck}, "R11 R12 esr_lock",
            {esr_vld, esr_locked}, {m_vld, m_lck});
    endtask

    task automatic idle();
        {dchk_vld, dchk_rx, dchk_ready, dchk_first, dchk_last, dchk_backed} = '0;
        dchk_chan = '0; pb_err_chan = '0; pb_err_kind = '0;
        {pb_err_vld, pb_err_rx, sb_err, esr_clr} = '0;
        {act_set_tx, act_set_rx, deir_clr_tx, deir_clr_rx} = '0;
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare();
        idle();
    endtask

    task automatic dchk(input logic rx, input int ch, input logic rdy, f, l, b);
        dchk_vld = 1; dchk_rx = rx; dchk_chan = CW'(ch);
        dchk_ready = rdy; dchk_first = f; dchk_last = l; dchk_backed = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(); lock_mode = 0; rst = 1;
        repeat (3) @(negedge clk);
        rst = 0; model_reset();
        // reset state: R3 R4 R9
        chk(tx_active == 0 && rx_active == 0, "R3 reset active", {tx_active, rx_active}, 0);
        chk(tx_deir == 0 && rx_deir == 0, "R4 reset deir", {tx_deir, rx_deir}, 0);
        chk(esr_type == 0 && !esr_vld, "R9 reset esr", esr_type, 0);

        act_set_tx = '1; act_set_rx = '1; step();
        // R2: first descriptor excused
        dchk(0, 2, 0, 1, 0, 0); step();
        chk(tx_active == 4'hF && tx_deir == 0, "R2 first excused", {tx_active, tx_deir}, 8'hF0);
        // R2: backed-up, not last excused
        dchk(0, 2, 0, 0, 0, 1); step();
        chk(tx_deir == 0 && !txde_irq, "R2 backed non-last", tx_deir, 0);
        // R1/R4: backed-up last flagged
        dchk(0, 2, 0, 0, 1, 1); step();
        chk(tx_deir == 4'b0100 && tx_active == 4'b1011, "R4 backed last",
            {tx_active, tx_deir}, 8'hB4);
        chk(esr_type == 3'd1 && esr_chan == 2, "R9 desc record", esr_type, 1);
        // R6: reactivate halted channel
        act_set_tx = 4'b0110; step();
        chk(tx_ptr_rst == 4'b0100, "R6 ptr pulse", tx_ptr_rst, 4'b0100);
        step();
        chk(tx_ptr_rst == 0, "R6 single pulse", tx_ptr_rst, 0);
        // R4: set beats clear, R3: error beats set
        dchk(1, 1, 0, 1, 1, 0); deir_clr_rx = 4'b0010; act_set_rx = 4'b0010; step();
        chk(rx_deir == 4'b0010 && !rx_active[1], "R4 set over clear", rx_deir, 2);
        // R10: both buses in same cycle; rx1 desc vs tx3 pb -> tx3 wins
        dchk(1, 1, 0, 0, 0, 0); pb_err_vld = 1; pb_err_rx = 0; pb_err_chan = 3;
        pb_err_kind = 2'b01; sb_err = 1; step();
        chk(esr_type == 3'd3 && esr_chan == 3 && !esr_rx, "R10 priority", esr_type, 3);
        // R8: system bus only
        act_set_tx = '1; step();
        sb_err = 1; step();
        chk(esr_type == 3'd5 && !esr_chv && tx_active == 4'hF, "R8 sbus", esr_type, 5);
        // R11: lock
        lock_mode = 1; pb_err_vld = 1; pb_err_kind = 2'b00; pb_err_rx = 1; pb_err_chan = 0; step();
        sb_err = 1; step();
        chk(esr_locked && esr_type == 3'd2, "R11 locked hold", esr_type, 2);
        // R12: clear with coincident error
        esr_clr = 1; sb_err = 1; step();
        chk(esr_type == 3'd5 && esr_locked, "R12 clear plus error", esr_type, 5);
        esr_clr = 1; step();
        chk(!esr_vld && !esr_locked, "R12 clear", {esr_vld, esr_locked}, 0);
        lock_mode = 0;

        void'($urandom(32'd4711));
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(99) < 35) dchk($urandom_range(1), $urandom_range(NCH-1),
                $urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1));
            if ($urandom_range(99) < 12) begin
                pb_err_vld = 1; pb_err_rx = $urandom_range(1);
                pb_err_chan = CW'($urandom_range(NCH-1)); pb_err_kind = 2'($urandom_range(3));
            end
            sb_err = ($urandom_range(99) < 6);
            act_set_tx = NCH'($urandom) & NCH'($urandom);
            act_set_rx = NCH'($urandom) & NCH'($urandom);
            if ($urandom_range(99) < 15) deir_clr_tx = NCH'($urandom);
            if ($urandom_range(99) < 15) deir_clr_rx = NCH'($urandom);
            esr_clr = ($urandom_range(99) < 5);
            if ($urandom_range(99) < 3) lock_mode = ~lock_mode;
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule